// File: doc/BRIEF.md
# Sparse-Space PCI Address Translator

This block sits between a CPU-side request port and a PCI master. The CPU reaches PCI memory and I/O through a sparse window. In that window each PCI byte takes up 32 CPU byte addresses, and the low CPU address bits carry the transfer size instead of address. The block recovers the PCI byte address from this layout. It produces byte enables and a lane-aligned 32-bit write word, and it pulls the addressed lane out of the returned 32-bit read word.

For memory space, only the low 27 PCI address bits come from the CPU address. The upper PCI bits come from an extension register that software loads ahead of the access. The CPU address is compared against a memory base: addresses at or above it are memory, and addresses below it are I/O. A quadword request becomes two longword PCI cycles issued back to back, and the two read halves are merged into one 64-bit response. A word request that would cross a longword boundary is rejected without any PCI cycle.

Top module: `sparse_pci_xlate`

## Requirements
- R1: After reset the block is ready for a request, no PCI cycle is pending, no response is flagged, and the extension register holds zero.
- R2: The PCI byte address is the sparse offset shifted right by 5. For I/O space the sparse offset is the CPU address itself and the PCI bits above it are zero.
- R3: For memory space the low 27 PCI address bits are offset bits [31:5]. Offset bits above 31 are ignored. PCI bits [31:27] are the extension register value at the moment the request is accepted.
- R4: A CPU address at or above MEM_BASE is memory space (pci_mem=1) with offset = address - MEM_BASE. Any lower address is I/O space (pci_mem=0).
- R5: Offset bits [4:3] give the size: 0 byte, 1 word, 3 longword, 2 quadword. The lane is offset bits [6:5]. Byte enables are 1<<lane for a byte, 3<<lane for a word, and 4'hF for a longword or quadword. Longword and quadword PCI addresses have bits [1:0] cleared.
- R6: Write data is placed in the addressed lane: a byte goes to bits [8*lane+7:8*lane] and a word to [8*lane+15:8*lane]. A longword carries the low 32 bits unchanged.
- R7: Read responses are zero-extended to 64 bits. A byte or word read returns the addressed lane of the PCI read word. A longword read returns the whole 32-bit word. Write responses return zero data.
- R8: A word request at lane 3 is answered on the next cycle with rsp_err=1 and zero data, and no PCI cycle is issued.
- R9: A quadword is issued as a longword at PCI address A carrying write bits [31:0], then, in the cycle after the first completes, a longword at A+4 carrying bits [63:32]. The read response is {second word, first word}.
- R10: From acceptance until the response, req_ready is low. A pending PCI cycle keeps its address, enables and data steady until pci_done. The response pulse comes in the cycle after the final pci_done.
- R11: Writing the extension register while a PCI cycle is pending does not change that cycle's address. The new value applies only to later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_we | input | 1 | Extension register write strobe |
| ext_wdata | input | PCI_AW-PASS_W | Extension register write value |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | CPU_AW | CPU sparse-window address |
| req_wdata | input | 64 | CPU write data |
| pci_valid | output | 1 | PCI cycle pending |
| pci_write | output | 1 | PCI cycle direction |
| pci_mem | output | 1 | 1 = memory space, 0 = I/O space |
| pci_addr | output | PCI_AW | PCI byte address |
| pci_be | output | 4 | PCI byte enables |
| pci_wdata | output | 32 | Lane-aligned PCI write data |
| pci_done | input | 1 | PCI cycle complete |
| pci_rdata | input | 32 | PCI read word, valid with pci_done |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Request rejected as misaligned |
| rsp_rdata | output | 64 | Response read data |

## Verification
The bench sweeps every combination of size code, lane, space and direction. The sweep tells apart lane placement in each direction, enable shapes, and the I/O versus memory address paths. Memory accesses use changing extension values, and some set offset bit 32, which must not reach the PCI address. Separate runs hold pci_done off for several cycles to show outputs stay steady. Others write the extension register mid-cycle to show the in-flight address is kept. Quadword runs use distinct low and high read words, so a swapped merge or a missing +4 step is visible. The misaligned word case must produce an error with no PCI cycle at all.

// File: rtl/sparse_pci_xlate.sv
module sparse_pci_xlate #(
  parameter int CPU_AW = 34,
  parameter int PCI_AW = 32,
  parameter int PASS_W = 27,
  parameter logic [CPU_AW-1:0] MEM_BASE = 34'h1_0000_0000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ext_we,
  input  logic [PCI_AW-PASS_W-1:0]   ext_wdata,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic [CPU_AW-1:0]          req_addr,
  input  logic [63:0]                req_wdata,
  output logic                       pci_valid,
  output logic                       pci_write,
  output logic                       pci_mem,
  output logic [PCI_AW-1:0]          pci_addr,
  output logic [3:0]                 pci_be,
  output logic [31:0]                pci_wdata,
  input  logic                       pci_done,
  input  logic [31:0]                pci_rdata,
  output logic                       rsp_valid,
  output logic                       rsp_err,
  output logic [63:0]                rsp_rdata
);
  localparam int EXT_W = PCI_AW - PASS_W;
  localparam int SHIFT = 5;
  localparam logic [1:0] SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_QUAD = 2'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_LO, ST_HI} st_t;
  st_t st;

  logic [EXT_W-1:0] ext_q;
  logic [1:0]       size_q, lane_q;
  logic [31:0]      hi_q, lo_q;

  wire              is_mem = req_addr >= MEM_BASE;
  wire [CPU_AW-1:0] off    = is_mem ? req_addr - MEM_BASE : req_addr;
  wire [1:0]        size   = off[4:3];
  wire [1:0]        lane   = off[6:5];
  wire              misal  = size == SZ_WORD && lane == 2'd3;
  wire              unused_low = ^off[2:0];

  wire [PCI_AW-1:0] a_io   = PCI_AW'(off[CPU_AW-1:SHIFT]);
  wire [PCI_AW-1:0] a_mem  = {ext_q, off[SHIFT+PASS_W-1:SHIFT]};
  wire [PCI_AW-1:0] a_sel  = is_mem ? a_mem : a_io;
  wire              narrow = size == SZ_BYTE || size == SZ_WORD;
  wire [PCI_AW-1:0] a_fin  = narrow ? a_sel : {a_sel[PCI_AW-1:2], 2'b00};

  logic [3:0]  be_c;
  logic [31:0] wd_c;
  always_comb begin
    case (size)
      SZ_BYTE: begin be_c = 4'b0001 << lane; wd_c = 32'(req_wdata[7:0])  << {lane, 3'b000}; end
      SZ_WORD: begin be_c = 4'b0011 << lane; wd_c = 32'(req_wdata[15:0]) << {lane, 3'b000}; end
      default: begin be_c = 4'b1111;         wd_c = req_wdata[31:0]; end
    endcase
  end

  wire [31:0] rsh = pci_rdata >> {lane_q, 3'b000};
  logic [63:0] rd_c;
  always_comb begin
    case (size_q)
      SZ_BYTE: rd_c = 64'(rsh[7:0]);
      SZ_WORD: rd_c = 64'(rsh[15:0]);
      default: rd_c = 64'(pci_rdata);
    endcase
  end

  assign pci_valid = st != ST_IDLE;
  assign req_ready = st == ST_IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      ext_q <= '0;
      size_q <= '0;
      lane_q <= '0;
      hi_q <= '0;
      lo_q <= '0;
      pci_write <= 1'b0;
      pci_mem <= 1'b0;
      pci_addr <= '0;
      pci_be <= '0;
      pci_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_err <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (ext_we) ext_q <= ext_wdata;
      case (st)
        ST_IDLE: if (req_valid) begin
          if (misal) begin
            rsp_valid <= 1'b1;
            rsp_err <= 1'b1;
            rsp_rdata <= '0;
          end else begin
            st <= ST_LO;
            size_q <= size;
            lane_q <= lane;
            hi_q <= req_wdata[63:32];
            pci_write <= req_write;
            pci_mem <= is_mem;
            pci_addr <= a_fin;
            pci_be <= be_c;
            pci_wdata <= wd_c;
          end
        end
        ST_LO: if (pci_done) begin
          if (size_q == SZ_QUAD) begin
            st <= ST_HI;
            lo_q <= pci_rdata;
            pci_addr <= pci_addr + PCI_AW'(4);
            pci_wdata <= hi_q;
          end else begin
            st <= ST_IDLE;
            rsp_valid <= 1'b1;
            rsp_err <= 1'b0;
            rsp_rdata <= pci_write ? 64'd0 : rd_c;
          end
        end
        ST_HI: if (pci_done) begin
          st <= ST_IDLE;
          rsp_valid <= 1'b1;
          rsp_err <= 1'b0;
          rsp_rdata <= pci_write ? 64'd0 : {pci_rdata, lo_q};
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pci_valid && !pci_done |=> pci_valid && $stable(pci_addr) && $stable(pci_be) && $stable(pci_wdata));

  a_r5_be_shape: assert property (@(posedge clk) disable iff (!rst_n)
    pci_valid |-> pci_be inside {4'h1, 4'h2, 4'h4, 4'h8, 4'h3, 4'h6, 4'hC, 4'hF});

  a_r9_second_half: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_LO && pci_done && size_q == SZ_QUAD |=> pci_valid && pci_addr == $past(pci_addr) + PCI_AW'(4) && pci_be == 4'hF);

  a_r8_no_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> !pci_valid && $past(!pci_valid));

  a_r2_io_range: assert property (@(posedge clk) disable iff (!rst_n)
    pci_valid && !pci_mem |-> pci_addr < PCI_AW'(MEM_BASE >> SHIFT));

  a_r10_resp_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_err |-> $past(pci_valid && pci_done));
endmodule

// File: tb/sparse_pci_xlate_test.sv
`timescale 1ns/1ps
module sparse_pci_xlate_test;
  localparam logic [63:0] MEMB = 64'h1_0000_0000;

  logic clk = 0, rst_n = 0;
  logic ext_we = 0;
  logic [4:0] ext_wdata = 0;
  logic req_valid = 0, req_write = 0;
  logic [33:0] req_addr = 0;
  logic [63:0] req_wdata = 0;
  logic pci_done = 0;
  logic [31:0] pci_rdata = 0;
  logic req_ready, pci_valid, pci_write, pci_mem, rsp_valid, rsp_err;
  logic [31:0] pci_addr, pci_wdata;
  logic [3:0] pci_be;
  logic [63:0] rsp_rdata;

  int tests = 0, fails = 0;
  logic [4:0] ext_model = 0;

  sparse_pci_xlate uut (
    .clk(clk), .rst_n(rst_n), .ext_we(ext_we), .ext_wdata(ext_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .pci_valid(pci_valid), .pci_write(pci_write), .pci_mem(pci_mem),
    .pci_addr(pci_addr), .pci_be(pci_be), .pci_wdata(pci_wdata),
    .pci_done(pci_done), .pci_rdata(pci_rdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata));

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_ext(input logic [4:0] v);
    @(negedge clk); ext_we = 1; ext_wdata = v;
    @(negedge clk); ext_we = 0; ext_model = v;
  endtask

  task automatic access(input bit wr, input logic [63:0] addr, input logic [63:0] wd,
                        input logic [31:0] rlo, input logic [31:0] rhi,
                        input int hold, input bit poke);
    logic [63:0] off, ea, er;
    logic [31:0] ew;
    logic [3:0] ebe;
    bit mem;
    int sz, ln;
    mem = addr >= MEMB;
    off = mem ? addr - MEMB : addr;
    sz = int'((off / 8) % 4);
    ln = int'((off / 32) % 4);
    if (mem) ea = (off / 32) % (64'd1 << 27) + 64'(ext_model) * (64'd1 << 27);
    else ea = off / 32;
    if (sz >= 2) ea = ea - 64'(ln);
    case (sz)
      0: begin ebe = 4'(1 << ln); ew = 32'((wd % 256) << (8 * ln)); end
      1: begin ebe = 4'(3 << ln); ew = 32'((wd % 65536) << (8 * ln)); end
      default: begin ebe = 4'hF; ew = wd[31:0]; end
    endcase
    case (sz)
      0: er = 64'((rlo >> (8 * ln)) % 256);
      1: er = 64'((rlo >> (8 * ln)) % 65536);
      2: er = {rhi, rlo};
      default: er = 64'(rlo);
    endcase
    if (wr) er = 0;

    @(negedge clk);
    chk("R10 ready before request", 64'(req_ready), 1);
    req_valid = 1; req_write = wr; req_addr = addr[33:0]; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    if (sz == 1 && ln == 3) begin
      chk("R8 misaligned error flagged", {62'd0, rsp_valid, rsp_err}, 3);
      chk("R8 misaligned data zero", rsp_rdata, 0);
      chk("R8 no PCI cycle", 64'(pci_valid), 0);
      @(negedge clk);
      chk("R8 still no PCI cycle", 64'(pci_valid), 0);
      return;
    end
    chk("R10 PCI cycle pending", 64'(pci_valid), 1);
    chk("R10 busy while pending", 64'(req_ready), 0);
    chk(mem ? "R3 memory address" : "R2 io address", 64'(pci_addr), ea);
    chk("R4 space select", 64'(pci_mem), 64'(mem));
    chk("R5 byte enables", 64'(pci_be), 64'(ebe));
    chk("R10 direction", 64'(pci_write), 64'(wr));
    if (wr) chk("R6 lane write data", 64'(pci_wdata), 64'(ew));
    if (poke) begin
      ext_we = 1; ext_wdata = ~ext_model;
      @(negedge clk);
      ext_we = 0; ext_model = ~ext_model;
      chk("R11 in-flight address kept", 64'(pci_addr), ea);
    end
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R10 address held", 64'(pci_addr), ea);
      chk("R10 enables held", 64'(pci_be), 64'(ebe));
    end
    pci_done = 1; pci_rdata = rlo;
    @(negedge clk);
    pci_done = 0;
    if (sz == 2) begin
      chk("R9 second half pending", 64'(pci_valid), 1);
      chk("R9 second half address", 64'(pci_addr), ea + 4);
      chk("R9 second half enables", 64'(pci_be), 15);
      if (wr) chk("R9 second half data", 64'(pci_wdata), wd >> 32);
      chk("R9 no early response", 64'(rsp_valid), 0);
      pci_done = 1; pci_rdata = rhi;
      @(negedge clk);
      pci_done = 0;
    end
    chk("R10 response pulse", {62'd0, rsp_valid, rsp_err}, 2);
    chk(sz == 2 ? "R9 merged read data" : "R7 read data", rsp_rdata, er);
    chk("R10 idle after response", 64'(pci_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready after reset", 64'(req_ready), 1);
    chk("R1 no pending cycle", 64'(pci_valid), 0);
    chk("R1 no response", 64'(rsp_valid), 0);
    access(0, MEMB + 64'h0000_0080 + 64'h18, 0, 32'hCAFE_F00D, 0, 0, 0);

    for (int sp = 0; sp < 2; sp++)
      for (int sz = 0; sz < 4; sz++) begin
        if (sp == 1) set_ext(5'(3 + 7 * sz));
        for (int ln = 0; ln < 4; ln++)
          for (int wr = 0; wr < 2; wr++) begin
            logic [63:0] off, a;
            off = 64'((sz * 37 + ln * 11 + wr * 5 + 1) * 4096) * 128
                  + 64'(ln * 32) + 64'(sz * 8);
            if (sp == 1 && ln == 2) off = off + (64'd1 << 32);
            a = (sp == 1) ? MEMB + off : off;
            access(wr[0], a, 64'h8877_6655_4433_2211 + 64'(sz * 16 + ln),
                   32'hA1B2_C3D4 ^ 32'(ln * 257), 32'h5E6F_7081 + 32'(sz), ln % 3, 0);
          end
      end

    set_ext(5'h12);
    access(0, MEMB + 64'h40_0000 + 64'h10, 0, 32'h1111_2222, 32'h3333_4444, 2, 1);
    access(1, MEMB + 64'h40_0000 + 64'h18, 64'hDEAD_BEEF, 0, 0, 0, 0);
    access(1, 64'h20 * 3 + 64'h08, 64'hABCD, 0, 0, 0, 0);
    access(0, 64'h7FF_FFE0, 0, 32'h9988_7766, 0, 1, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule